// File: doc/BRIEF.md
# RV64 Bit-Manipulation Integer ALU

This block is the integer execute stage for a 64-bit core that supports the base integer operations plus the address-generation and bit-manipulation additions. Each cycle it can accept one operation: two 64-bit source operands and a 7-bit operation code. One cycle later it returns a 64-bit result and a branch-taken flag, marked by an output valid strobe.

The upper three bits of the operation code pick an operation class, and each class is served by its own small unit: shift/rotate/single-bit, arithmetic (add, shifted add, subtract, compare, word add/sub), logic, and branch compare. A branch operation produces only the taken flag and a zero result. Any operation code that is not listed below yields a zero result with the flag clear. Issuing an operation requires no handshake and nothing else. The output register holds its last value while no operation is issued.

Top module: `rvb_alu`

## Requirements
- R1: Opcode bits [6:4] select the class: 000 shift/bit, 001 word, 010 add, 011 subtract/compare, 100 logic, 111 branch. An opcode not listed in R2 to R9 (for example 7'h08, 7'h11, 7'h46, 7'h74, and any code with bits [6:4] = 101 or 110) returns result 0 with taken 0.
- R2: 64-bit shifts take their amount from src2[5:0]: 7'h01 left logical, 7'h05 right logical, 7'h07 right arithmetic. 7'h00 shifts zero-extended src1[31:0] left by src2[5:0].
- R3: Single-bit operations take the bit index from src2[5:0] only: 7'h02 clears that bit of src1, 7'h03 sets it, 7'h04 inverts it, 7'h06 returns that bit of src1 in result bit 0 with every other bit zero.
- R4: 7'h09 rotates src1 left and 7'h0B rotates it right by src2[5:0]. A rotate amount of 0 returns src1 unchanged.
- R5: Word operations act on 32 bits and sign-extend bit 31 of the 32-bit result into bits [63:32]: 7'h10 add, 7'h12 subtract, 7'h18 shift left, 7'h19 shift right logical of src1[31:0], 7'h1A shift right arithmetic of src1[31:0], 7'h1C rotate left, 7'h1D rotate right, with the amount from src2[4:0].
- R6: 7'h21 returns src1+src2 and 7'h20 returns ZEXT(src1[31:0])+src2. Shifted adds return (X<<k)+src2, where X = src1 for 7'h29 (k=1), 7'h2B (k=2), 7'h2D (k=3) and 7'h2F (k=4), and X = ZEXT(src1[31:0]) for 7'h28 (k=1), 7'h2A (k=2) and 7'h2C (k=3).
- R7: 7'h30 returns src1-src2. 7'h31 returns 1 when src1 < src2 unsigned and 7'h32 returns 1 when src1 < src2 signed, otherwise 0. 7'h34 returns the unsigned maximum, 7'h35 the unsigned minimum, 7'h36 the signed maximum and 7'h37 the signed minimum.
- R8: Logic: 7'h40 AND, 7'h42 OR and 7'h44 XOR of src1 and src2. 7'h41, 7'h43 and 7'h45 apply AND, OR and XOR to src1 and the bitwise inverse of src2.
- R9: Branch class 111: bits [3:2] select the compare (00 equal, 10 signed less-than, 11 unsigned less-than), bit 1 = 1 inverts the outcome, and bit 0 must be 0. This gives 7'h70 eq, 7'h72 ne, 7'h78 lt, 7'h7A ge, 7'h7C ltu, 7'h7E geu. The result is 0, and taken is high only for a branch opcode whose condition holds.
- R10: out_valid equals in_valid delayed by exactly one clock. out_result and out_taken update only on a cycle with in_valid high, and otherwise hold their values.
- R11: While rst is high at a clock edge, out_valid, out_result and out_taken all become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issued this cycle |
| in_op | input | 7 | Operation code |
| in_src1 | input | 64 | First operand |
| in_src2 | input | 64 | Second operand / shift amount / bit index |
| out_valid | output | 1 | Result valid, one cycle after issue |
| out_result | output | 64 | Registered result |
| out_taken | output | 1 | Registered branch-taken flag |

## Verification
The only state is the single output register, so a fault inside the block shows on the ports at the next clock edge. A wrong class selection or index slice appears as a wrong result exactly one cycle after issue. A capture-enable fault appears as a result that changes during an idle cycle. A valid-pipeline fault appears as out_valid out of step with in_valid by one cycle. Operands are chosen so that index bits above 5, upper source halves, sign bits and equal operands each change the expected answer. A slicing, extension or inversion error therefore cannot pass unnoticed.

// File: rtl/rvb_alu_pkg.sv
package rvb_alu_pkg;

    localparam int XLEN   = 64;
    localparam int WLEN   = XLEN / 2;
    localparam int SHW    = $clog2(XLEN);
    localparam int WSHW   = $clog2(WLEN);
    localparam int OPW    = 7;

    typedef logic [XLEN-1:0] xword_t;
    typedef logic [WLEN-1:0] hword_t;
    typedef logic [OPW-1:0]  op_t;

    typedef enum logic [2:0] {
        CLS_SHIFT  = 3'b000,
        CLS_WORD   = 3'b001,
        CLS_ADD    = 3'b010,
        CLS_SUB    = 3'b011,
        CLS_LOGIC  = 3'b100,
        CLS_SPARE5 = 3'b101,
        CLS_SPARE6 = 3'b110,
        CLS_BRANCH = 3'b111
    } op_class_e;

    // shift / single-bit class
    localparam op_t OP_SLL_ZW  = 7'h00;
    localparam op_t OP_SLL     = 7'h01;
    localparam op_t OP_BIT_CLR = 7'h02;
    localparam op_t OP_BIT_SET = 7'h03;
    localparam op_t OP_BIT_INV = 7'h04;
    localparam op_t OP_SRL     = 7'h05;
    localparam op_t OP_BIT_GET = 7'h06;
    localparam op_t OP_SRA     = 7'h07;
    localparam op_t OP_ROTL    = 7'h09;
    localparam op_t OP_ROTR    = 7'h0B;
    // word class
    localparam op_t OP_ADD_W   = 7'h10;
    localparam op_t OP_SUB_W   = 7'h12;
    localparam op_t OP_SLL_W   = 7'h18;
    localparam op_t OP_SRL_W   = 7'h19;
    localparam op_t OP_SRA_W   = 7'h1A;
    localparam op_t OP_ROTL_W  = 7'h1C;
    localparam op_t OP_ROTR_W  = 7'h1D;
    // add class
    localparam op_t OP_ADD_ZW  = 7'h20;
    localparam op_t OP_ADD     = 7'h21;
    localparam op_t OP_SA1_ZW  = 7'h28;
    localparam op_t OP_SA1     = 7'h29;
    localparam op_t OP_SA2_ZW  = 7'h2A;
    localparam op_t OP_SA2     = 7'h2B;
    localparam op_t OP_SA3_ZW  = 7'h2C;
    localparam op_t OP_SA3     = 7'h2D;
    localparam op_t OP_SA4     = 7'h2F;
    // subtract / compare class
    localparam op_t OP_SUB     = 7'h30;
    localparam op_t OP_LT_U    = 7'h31;
    localparam op_t OP_LT_S    = 7'h32;
    localparam op_t OP_MAX_U   = 7'h34;
    localparam op_t OP_MIN_U   = 7'h35;
    localparam op_t OP_MAX_S   = 7'h36;
    localparam op_t OP_MIN_S   = 7'h37;
    // logic class
    localparam op_t OP_AND     = 7'h40;
    localparam op_t OP_AND_INV = 7'h41;
    localparam op_t OP_OR      = 7'h42;
    localparam op_t OP_OR_INV  = 7'h43;
    localparam op_t OP_XOR     = 7'h44;
    localparam op_t OP_XOR_INV = 7'h45;

    // branch compare selector, op[3:2]
    localparam logic [1:0] BR_EQ  = 2'b00;
    localparam logic [1:0] BR_LT  = 2'b10;
    localparam logic [1:0] BR_LTU = 2'b11;

    typedef struct packed {
        logic   hit;
        xword_t value;
    } unit_out_t;

    function automatic op_class_e class_of(op_t op);
        return op_class_e'(op[6:4]);
    endfunction

    function automatic xword_t sext_half(hword_t h);
        return {{WLEN{h[WLEN-1]}}, h};
    endfunction

    function automatic xword_t zext_half(xword_t x);
        return {{WLEN{1'b0}}, x[WLEN-1:0]};
    endfunction

endpackage

// File: rtl/rvb_shift_unit.sv
module rvb_shift_unit
    import rvb_alu_pkg::*;
(
    input  op_t       op,
    input  xword_t    src1,
    input  xword_t    src2,
    output unit_out_t res
);

    logic [SHW-1:0]  amt;
    logic [WSHW-1:0] wamt;
    logic [SHW:0]    ramt;
    logic [WSHW:0]   wramt;
    xword_t          onehot;
    xword_t          sra_v;
    hword_t          lo;
    hword_t          sll_w, srl_w, sra_w, rotl_w, rotr_w;

    assign amt    = src2[SHW-1:0];
    assign wamt   = src2[WSHW-1:0];
    assign ramt   = (SHW+1)'(XLEN) - {1'b0, amt};
    assign wramt  = (WSHW+1)'(WLEN) - {1'b0, wamt};
    assign onehot = xword_t'(1) << amt;
    assign sra_v  = xword_t'($signed(src1) >>> amt);
    assign lo     = src1[WLEN-1:0];
    assign sll_w  = lo << wamt;
    assign srl_w  = lo >> wamt;
    assign sra_w  = hword_t'($signed(lo) >>> wamt);
    assign rotl_w = (lo << wamt) | (lo >> wramt);
    assign rotr_w = (lo >> wamt) | (lo << wramt);

    always_comb begin
        res = '0;
        res.hit = 1'b1;
        case (op)
            OP_SLL_ZW:  res.value = zext_half(src1) << amt;
            OP_SLL:     res.value = src1 << amt;
            OP_BIT_CLR: res.value = src1 & ~onehot;
            OP_BIT_SET: res.value = src1 | onehot;
            OP_BIT_INV: res.value = src1 ^ onehot;
            OP_SRL:     res.value = src1 >> amt;
            OP_BIT_GET: res.value = {{(XLEN-1){1'b0}}, src1[amt]};
            OP_SRA:     res.value = sra_v;
            OP_ROTL:    res.value = (src1 << amt) | (src1 >> ramt);
            OP_ROTR:    res.value = (src1 >> amt) | (src1 << ramt);
            OP_SLL_W:   res.value = sext_half(sll_w);
            OP_SRL_W:   res.value = sext_half(srl_w);
            OP_SRA_W:   res.value = sext_half(sra_w);
            OP_ROTL_W:  res.value = sext_half(rotl_w);
            OP_ROTR_W:  res.value = sext_half(rotr_w);
            default:    res.hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/rvb_arith_unit.sv
module rvb_arith_unit
    import rvb_alu_pkg::*;
(
    input  op_t       op,
    input  xword_t    src1,
    input  xword_t    src2,
    output unit_out_t res
);

    logic [XLEN:0] diff;
    logic          lt_u;
    logic          lt_s;
    xword_t        sum;
    xword_t        zsrc1;

    assign diff  = {1'b0, src1} - {1'b0, src2};
    assign lt_u  = diff[XLEN];
    assign lt_s  = (src1[XLEN-1] != src2[XLEN-1]) ? src1[XLEN-1] : diff[XLEN-1];
    assign sum   = src1 + src2;
    assign zsrc1 = zext_half(src1);

    always_comb begin
        res = '0;
        res.hit = 1'b1;
        case (op)
            OP_ADD_W:  res.value = sext_half(sum[WLEN-1:0]);
            OP_SUB_W:  res.value = sext_half(diff[WLEN-1:0]);
            OP_ADD_ZW: res.value = zsrc1 + src2;
            OP_ADD:    res.value = sum;
            OP_SA1_ZW: res.value = (zsrc1 << 1) + src2;
            OP_SA1:    res.value = (src1  << 1) + src2;
            OP_SA2_ZW: res.value = (zsrc1 << 2) + src2;
            OP_SA2:    res.value = (src1  << 2) + src2;
            OP_SA3_ZW: res.value = (zsrc1 << 3) + src2;
            OP_SA3:    res.value = (src1  << 3) + src2;
            OP_SA4:    res.value = (src1  << 4) + src2;
            OP_SUB:    res.value = diff[XLEN-1:0];
            OP_LT_U:   res.value = {{(XLEN-1){1'b0}}, lt_u};
            OP_LT_S:   res.value = {{(XLEN-1){1'b0}}, lt_s};
            OP_MAX_U:  res.value = lt_u ? src2 : src1;
            OP_MIN_U:  res.value = lt_u ? src1 : src2;
            OP_MAX_S:  res.value = lt_s ? src2 : src1;
            OP_MIN_S:  res.value = lt_s ? src1 : src2;
            default:   res.hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/rvb_logic_unit.sv
module rvb_logic_unit
    import rvb_alu_pkg::*;
(
    input  op_t       op,
    input  xword_t    src1,
    input  xword_t    src2,
    output unit_out_t res
);

    xword_t opnd2;

    // odd codes of the logic class use the inverted second operand
    assign opnd2 = op[0] ? ~src2 : src2;

    always_comb begin
        res = '0;
        res.hit = 1'b1;
        case (op)
            OP_AND, OP_AND_INV: res.value = src1 & opnd2;
            OP_OR,  OP_OR_INV:  res.value = src1 | opnd2;
            OP_XOR, OP_XOR_INV: res.value = src1 ^ opnd2;
            default:            res.hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/rvb_branch_unit.sv
module rvb_branch_unit
    import rvb_alu_pkg::*;
(
    input  op_t    op,
    input  xword_t src1,
    input  xword_t src2,
    output logic   taken
);

    logic cond;
    logic legal;

    always_comb begin
        cond  = 1'b0;
        legal = (class_of(op) == CLS_BRANCH) && !op[0];
        case (op[3:2])
            BR_EQ:   cond = (src1 == src2);
            BR_LT:   cond = ($signed(src1) < $signed(src2));
            BR_LTU:  cond = (src1 < src2);
            default: legal = 1'b0;
        endcase
        taken = legal && (cond ^ op[1]);
    end

endmodule

// File: rtl/rvb_alu.sv
module rvb_alu
    import rvb_alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [OPW-1:0]  in_op,
    input  logic [XLEN-1:0] in_src1,
    input  logic [XLEN-1:0] in_src2,
    output logic            out_valid,
    output logic [XLEN-1:0] out_result,
    output logic            out_taken
);

    unit_out_t shf_res, ari_res, log_res;
    logic      br_taken;
    xword_t    nxt_result;

    rvb_shift_unit u_shift (
        .op   (in_op),
        .src1 (in_src1),
        .src2 (in_src2),
        .res  (shf_res)
    );

    rvb_arith_unit u_arith (
        .op   (in_op),
        .src1 (in_src1),
        .src2 (in_src2),
        .res  (ari_res)
    );

    rvb_logic_unit u_logic (
        .op   (in_op),
        .src1 (in_src1),
        .src2 (in_src2),
        .res  (log_res)
    );

    rvb_branch_unit u_branch (
        .op    (in_op),
        .src1  (in_src1),
        .src2  (in_src2),
        .taken (br_taken)
    );

    // the units decode disjoint code sets; an unclaimed code leaves zero
    always_comb begin
        nxt_result = '0;
        if (shf_res.hit)      nxt_result = shf_res.value;
        else if (ari_res.hit) nxt_result = ari_res.value;
        else if (log_res.hit) nxt_result = log_res.value;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_taken  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= nxt_result;
                out_taken  <= br_taken;
            end
        end
    end

endmodule

// File: rtl/rvb_alu_checker.sv
module rvb_alu_checker
    import rvb_alu_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [OPW-1:0]  in_op,
    input logic [XLEN-1:0] in_src1,
    input logic [XLEN-1:0] in_src2,
    input logic            out_valid,
    input logic [XLEN-1:0] out_result,
    input logic            out_taken
);

    AST_VALID_ISSUE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid) else $error("valid lost");  // R10

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid) else $error("spurious valid");  // R10

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_taken))) else $error("output moved while idle");  // R10

    AST_TAKEN_BRANCH_ONLY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[6:4] != 3'b111) |=> !out_taken) else $error("taken outside branch class");  // R9

    AST_BRANCH_ZERO_RESULT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[6:4] == 3'b111) |=> (out_result == '0)) else $error("branch produced data");  // R9

    AST_WORD_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[6:4] == 3'b001) |=> (out_result[XLEN-1:WLEN] == {WLEN{out_result[WLEN-1]}})) else $error("word result not sign extended");  // R5

    AST_SPARE_CLASS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[6:4] == 3'b110) |=> (out_result == '0 && !out_taken)) else $error("unlisted code produced data");  // R1

    AST_BIT_GET_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 7'h06) |=> (out_result[XLEN-1:1] == '0)) else $error("bit extract wide");  // R3

    always @(posedge clk) begin
        if (!rst && $past(rst)) begin
            AST_RESET_CLEAR: assert (!out_valid && out_result == '0 && !out_taken) else $error("reset state");  // R11
        end
    end

endmodule

bind rvb_alu rvb_alu_checker u_rvb_alu_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_src1    (in_src1),
    .in_src2    (in_src2),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_taken  (out_taken)
);

// File: tb/rvb_alu_bench.sv
`timescale 1ns/100ps
module rvb_alu_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [6:0]  in_op = '0;
    logic [63:0] in_src1 = '0;
    logic [63:0] in_src2 = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_taken;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    rvb_alu u_rvb_alu (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_src1    (in_src1),
        .in_src2    (in_src2),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_taken  (out_taken)
    );

    // operand patterns
    logic [63:0] pa [6] = '{64'h8000_0000_F0F0_1234, 64'hFFFF_FFFF_8000_0001, 64'h0000_0000_0000_0123,
                            64'hFFFF_FFFF_FFFF_FFF0, 64'h7FFF_FFFF_7FFF_FFFF, 64'h0123_4567_89AB_CDEF};
    logic [63:0] pb [6] = '{64'h0000_0000_0000_0025, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_0000_0123,
                            64'h0000_0000_0000_0010, 64'hFFFF_FFFF_FFFF_FFC3, 64'h0000_0000_0000_0000};

    function automatic logic [64:0] model(logic [6:0] op, logic [63:0] a, logic [63:0] b);
        logic [5:0]   s6;
        logic [4:0]   s5;
        logic [63:0]  r;
        logic         t;
        logic [31:0]  w;
        logic [63:0]  za;
        logic [127:0] dbl;
        logic [63:0]  dw;
        logic         word;
        s6 = b[5:0]; s5 = b[4:0]; r = '0; t = 1'b0; w = '0; word = 1'b0;
        za = {32'h0, a[31:0]};
        case (op)
            7'h00: r = za << s6;
            7'h01: r = a << s6;
            7'h02: r = a & ~(64'h1 << s6);
            7'h03: r = a | (64'h1 << s6);
            7'h04: r = a ^ (64'h1 << s6);
            7'h05: r = a >> s6;
            7'h06: r = {63'h0, a[s6]};
            7'h07: r = $unsigned($signed(a) >>> s6);
            7'h09: begin dbl = {a, a} << s6; r = dbl[127:64]; end
            7'h0B: begin dbl = {a, a} >> s6; r = dbl[63:0]; end
            7'h10: begin w = a[31:0] + b[31:0]; word = 1'b1; end
            7'h12: begin w = a[31:0] - b[31:0]; word = 1'b1; end
            7'h18: begin w = a[31:0] << s5; word = 1'b1; end
            7'h19: begin w = a[31:0] >> s5; word = 1'b1; end
            7'h1A: begin w = $unsigned($signed(a[31:0]) >>> s5); word = 1'b1; end
            7'h1C: begin dw = {a[31:0], a[31:0]} << s5; w = dw[63:32]; word = 1'b1; end
            7'h1D: begin dw = {a[31:0], a[31:0]} >> s5; w = dw[31:0]; word = 1'b1; end
            7'h20: r = za + b;
            7'h21: r = a + b;
            7'h28: r = za * 2 + b;
            7'h29: r = a * 2 + b;
            7'h2A: r = za * 4 + b;
            7'h2B: r = a * 4 + b;
            7'h2C: r = za * 8 + b;
            7'h2D: r = a * 8 + b;
            7'h2F: r = a * 16 + b;
            7'h30: r = a - b;
            7'h31: r = (a < b) ? 64'd1 : 64'd0;
            7'h32: r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
            7'h34: r = (a > b) ? a : b;
            7'h35: r = (a > b) ? b : a;
            7'h36: r = ($signed(a) > $signed(b)) ? a : b;
            7'h37: r = ($signed(a) > $signed(b)) ? b : a;
            7'h40: r = a & b;
            7'h41: r = a & ~b;
            7'h42: r = a | b;
            7'h43: r = a | ~b;
            7'h44: r = a ^ b;
            7'h45: r = ~(a ^ b);
            7'h70: t = (a == b);
            7'h72: t = (a != b);
            7'h78: t = ($signed(a) < $signed(b));
            7'h7A: t = ($signed(a) >= $signed(b));
            7'h7C: t = (a < b);
            7'h7E: t = (a >= b);
            default: r = '0;
        endcase
        if (word) r = {{32{w[31]}}, w};
        return {t, r};
    endfunction

    task automatic check64(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // issue one operation at a falling edge, compare one cycle later
    task automatic run_op(string tag, logic [6:0] op, logic [63:0] a, logic [63:0] b,
                          logic [63:0] exp_r, logic exp_t);
        in_valid = 1'b1; in_op = op; in_src1 = a; in_src2 = b;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (out_valid !== 1'b1 || out_result !== exp_r || out_taken !== exp_t) begin
            failures++;
            $display("FAIL %s op=%h actual=%b/%h/%b expected=1/%h/%b",
                     tag, op, out_valid, out_result, out_taken, exp_r, exp_t);
        end
    endtask

    task automatic run_model(string tag, logic [6:0] op, logic [63:0] a, logic [63:0] b);
        logic [64:0] e;
        e = model(op, a, b);
        run_op(tag, op, a, b, e[63:0], e[64]);
    endtask

    task automatic sweep(string tag, logic [6:0] ops []);
        foreach (ops[i]) for (int p = 0; p < 6; p++) run_model(tag, ops[i], pa[p], pb[p]);
    endtask

    task automatic t_reset();
        checks++;
        if (out_valid !== 1'b0 || out_result !== 64'h0 || out_taken !== 1'b0) begin
            failures++;
            $display("FAIL R11 reset actual=%b/%h/%b expected=0/0/0", out_valid, out_result, out_taken);
        end
    endtask

    task automatic t_shifts();
        sweep("R2 shift", '{7'h00, 7'h01, 7'h05, 7'h07});
        run_op("R2 index above 5 ignored", 7'h01, 64'h1, 64'hFFC1, 64'h2, 1'b0);
        run_op("R2 sra sign", 7'h07, 64'h8000_0000_0000_0000, 64'd63, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    endtask

    task automatic t_bits();
        sweep("R3 bit", '{7'h02, 7'h03, 7'h04, 7'h06});
        run_op("R3 clear idx 70->6", 7'h02, 64'hFFFF_FFFF_FFFF_FFFF, 64'd70, 64'hFFFF_FFFF_FFFF_FFBF, 1'b0);
        run_op("R3 extract bit 63", 7'h06, 64'h8000_0000_0000_0000, 64'd63, 64'h1, 1'b0);
    endtask

    task automatic t_rotates();
        sweep("R4 rotate", '{7'h09, 7'h0B});
        run_op("R4 rotl by 0", 7'h09, 64'hDEAD_BEEF_0123_4567, 64'h40, 64'hDEAD_BEEF_0123_4567, 1'b0);
        run_op("R4 rotr by 0", 7'h0B, 64'hDEAD_BEEF_0123_4567, 64'h0, 64'hDEAD_BEEF_0123_4567, 1'b0);
        run_op("R4 rotr by 4", 7'h0B, 64'h0000_0000_0000_0012, 64'd4, 64'h2000_0000_0000_0001, 1'b0);
    endtask

    task automatic t_word();
        sweep("R5 word", '{7'h10, 7'h12, 7'h18, 7'h19, 7'h1A, 7'h1C, 7'h1D});
        run_op("R5 addw overflow", 7'h10, 64'h0000_0000_7FFF_FFFF, 64'h1, 64'hFFFF_FFFF_8000_0000, 1'b0);
        run_op("R5 srlw upper ignored", 7'h19, 64'hFFFF_FFFF_8000_0000, 64'd31, 64'h1, 1'b0);
        run_op("R5 rotlw by 0", 7'h1C, 64'h1234_5678_8765_4321, 64'h20, 64'hFFFF_FFFF_8765_4321, 1'b0);
    endtask

    task automatic t_add();
        sweep("R6 add", '{7'h20, 7'h21, 7'h28, 7'h29, 7'h2A, 7'h2B, 7'h2C, 7'h2D, 7'h2F});
        run_op("R6 sh3add.uw zext", 7'h2C, 64'hFFFF_FFFF_0000_0001, 64'd1, 64'd9, 1'b0);
    endtask

    task automatic t_cmp();
        sweep("R7 compare", '{7'h30, 7'h31, 7'h32, 7'h34, 7'h35, 7'h36, 7'h37});
        run_op("R7 slt neg", 7'h32, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd1, 1'b0);
        run_op("R7 sltu neg", 7'h31, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd0, 1'b0);
    endtask

    task automatic t_logic();
        sweep("R8 logic", '{7'h40, 7'h41, 7'h42, 7'h43, 7'h44, 7'h45});
        run_op("R8 orn", 7'h43, 64'h0, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_FFFF_FFFF, 1'b0);
    endtask

    task automatic t_branch();
        sweep("R9 branch", '{7'h70, 7'h72, 7'h78, 7'h7A, 7'h7C, 7'h7E});
        run_op("R9 bge signed", 7'h7A, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd0, 1'b0);
        run_op("R9 bgeu unsigned", 7'h7E, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd0, 1'b1);
        run_op("R9 beq equal", 7'h70, 64'h55, 64'h55, 64'd0, 1'b1);
    endtask

    task automatic t_unlisted();
        logic [6:0] bad [] = '{7'h08, 7'h0A, 7'h11, 7'h1B, 7'h22, 7'h33, 7'h46,
                               7'h50, 7'h60, 7'h71, 7'h74, 7'h76};
        foreach (bad[i]) run_op("R1 unlisted", bad[i], 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 1'b0);
    endtask

    task automatic t_hold();
        run_op("R10 setup", 7'h72, 64'h1, 64'h2, 64'h0, 1'b1);
        in_op = 7'h21; in_src1 = 64'h5; in_src2 = 64'h7;
        @(posedge clk);
        @(negedge clk);
        check64("R10 out_valid idle", {63'h0, out_valid}, 64'h0);
        check64("R10 result held", out_result, 64'h0);
        check64("R10 taken held", {63'h0, out_taken}, 64'h1);
        run_op("R10 back to back a", 7'h21, 64'h5, 64'h7, 64'hC, 1'b0);
        run_op("R10 back to back b", 7'h30, 64'h5, 64'h7, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_shifts();
        t_bits();
        t_rotates();
        t_word();
        t_add();
        t_cmp();
        t_logic();
        t_branch();
        t_unlisted();
        t_hold();
        in_valid = 1'b1; in_op = 7'h21; in_src1 = 64'h1; in_src2 = 64'h1;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        t_reset();
        rst = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R10 actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule